// File: doc/BRIEF.md
# Descriptor-Chain Buffer DMA Engine

This block is the internal DMA master of a memory-card host controller. It steers one block transfer across a sequence of memory buffers. Software loads five registers: the base of the descriptor area, then the first descriptor's link word, buffer base and buffer size, and last a control word with an enable bit and an optional chain bit. The engine then gives the data path one buffer at a time as a current address and a remaining byte count. Each `beatAck` from the data path moves one 32-bit word.

When a buffer runs out and chaining is on, the engine reads the next descriptor from memory. A descriptor is three words at the area base plus the offset held in the current link word: a link word, then a base, then a size. Flags in the fetched link word control three things: whether the base is taken or the address runs on from where the last buffer ended, whether the size is taken or the last size is reused, and whether another descriptor follows. With chaining off, the engine streams one buffer from the first base register and never reads memory. A buffer that breaks the alignment rules halts the engine with an error. A done pulse marks the end of the final buffer.

Top module: `chain_dma`

## Requirements
- R1: After reset, `busy`, `bufValid`, `memRdReq`, `done` and `errFlag` are all low.
- R2: Register map by `regAddr`:
  - 0 is control: bit0 enable, bit1 chain mode.
  - 1 is the descriptor area base.
  - 2 is the first link word.
  - 3 is the first buffer base.
  - 4 is the first buffer size.

  A control write with bit1 clear streams a single buffer of the first size from the first base. The first link word is ignored and no memory read is issued.
- R3: While bytes remain in the active buffer, `bufValid` is high and `bufAddr` shows the current address. Each accepted beat adds 4 to the address and takes min(4, remaining) from `bufRemain`.
- R4: A descriptor fetch reads three words, one request at a time, at area base + link offset (link bits 15:0) + 0, 4 and 8, in that order. `memRdReq` and `memRdAddr` hold until `memRdValid`.
- R5: Fetched fields take effect only after the third word arrives. `bufValid` stays low for the whole fetch.
- R6: Link bit 31 set means another descriptor follows the current buffer. Clear means the current buffer is the last, and no further read is issued.
- R7: In a fetched link word, bit 30 set loads the descriptor's size word. Clear reuses the previous buffer size.
- R8: In a fetched link word, bit 29 set loads the descriptor's base word. Clear continues from the address where the previous buffer ended.
- R9: Alignment rules:
  - A buffer whose base is not 4-byte aligned is an error.
  - A buffer that is not last and whose size is not a multiple of the burst size (16 bytes) is an error.
  - The last buffer needs only base alignment.

  On error the engine raises `errFlag`, drops `busy`, and issues no beat or read.
- R10: A control write with bit0 clear stops the engine from any state and clears `errFlag`. A control write with bit0 set while busy is ignored.
- R11: `done` is a one-cycle pulse, raised once per transfer when the last buffer's count reaches zero, with `busy` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| memRdReq | output | 1 | Descriptor word read request |
| memRdAddr | output | 32 | Descriptor word byte address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| bufValid | output | 1 | A buffer word is available to the data path |
| bufAddr | output | 32 | Current buffer byte address |
| bufRemain | output | 32 | Bytes left in the current buffer |
| beatAck | input | 1 | Data path consumed one word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |
| errFlag | output | 1 | Alignment error, engine halted |

## Verification
The properties assume that the memory side answers each request with exactly one `memRdValid` and never raises it when no request is pending. They also assume `beatAck` is meaningful only while `bufValid` is high. The bench's memory model keeps to both: it answers a held request after a fixed latency and stays quiet otherwise. The bench raises `beatAck` only in cycles where it sees `bufValid`. Control writes are issued in the idle state, except for the deliberate stop test. That keeps the fetch-hold property's exemption for stops narrow.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  localparam int REG_AW     = 3;
  localparam int BEAT_BYTES = 4;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_AREA = 3'd1;
  localparam logic [REG_AW-1:0] RA_LINK = 3'd2;
  localparam logic [REG_AW-1:0] RA_BASE = 3'd3;
  localparam logic [REG_AW-1:0] RA_SIZE = 3'd4;

  localparam int LNK_CONT = 31;
  localparam int LNK_SIZE = 30;
  localparam int LNK_BASE = 29;

  localparam int DESC_WORDS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_STREAM,
    ST_FETCH,
    ST_COMMIT,
    ST_ERR
  } dmaState_e;

  typedef struct packed {
    logic start;
    logic listMode;
    logic capture;
    logic commit;
    logic beat;
  } dpStrobe_s;

endpackage

// File: rtl/chain_dma_datapath.sv
module chain_dma_datapath
  import chain_dma_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int OFF_W       = 16,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  dpStrobe_s         strobe,
  input  logic [WORD_W-1:0] memRdData,
  output logic              ctrlWr,
  output logic              ctrlEn,
  output logic              ctrlList,
  output logic [WORD_W-1:0] memRdAddr,
  output logic [WORD_W-1:0] bufAddr,
  output logic [WORD_W-1:0] bufRemain,
  output logic              alignBad,
  output logic              lastBuf,
  output logic              remZero,
  output logic              idxLast
);

  localparam int BURST_LG = $clog2(BURST_BYTES);
  localparam int IDX_W    = $clog2(DESC_WORDS);

  logic [WORD_W-1:0] cfgArea, cfgLink, cfgBase, cfgSize;
  logic [WORD_W-1:0] curLink, curAddr, curRem, curSize;
  logic [WORD_W-1:0] fWord [DESC_WORDS];
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] take;

  assign ctrlWr   = regWrEn && (regAddr == RA_CTRL);
  assign ctrlEn   = regWrData[0];
  assign ctrlList = regWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgArea <= '0;
      cfgLink <= '0;
      cfgBase <= '0;
      cfgSize <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        RA_AREA: cfgArea <= regWrData;
        RA_LINK: cfgLink <= regWrData;
        RA_BASE: cfgBase <= regWrData;
        RA_SIZE: cfgSize <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strobe.start || strobe.commit) begin
      idx <= '0;
    end else if (strobe.capture) begin
      idx <= idx + 1'b1;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fWord[g] <= '0;
      end else if (strobe.capture && (idx == IDX_W'(g))) begin
        fWord[g] <= memRdData;
      end
    end
  end

  assign take = (curRem < WORD_W'(BEAT_BYTES)) ? curRem : WORD_W'(BEAT_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLink <= '0;
      curAddr <= '0;
      curRem  <= '0;
      curSize <= '0;
    end else if (strobe.start) begin
      curLink <= strobe.listMode ? cfgLink : '0;
      curAddr <= cfgBase;
      curRem  <= cfgSize;
      curSize <= cfgSize;
    end else if (strobe.commit) begin
      curLink <= fWord[0];
      if (fWord[0][LNK_BASE]) curAddr <= fWord[1];
      if (fWord[0][LNK_SIZE]) begin
        curRem  <= fWord[2];
        curSize <= fWord[2];
      end else begin
        curRem  <= curSize;
      end
    end else if (strobe.beat) begin
      curAddr <= curAddr + WORD_W'(BEAT_BYTES);
      curRem  <= curRem - take;
    end
  end

  assign memRdAddr = cfgArea + WORD_W'(curLink[OFF_W-1:0]) + (WORD_W'(idx) << 2);
  assign bufAddr   = curAddr;
  assign bufRemain = curRem;
  assign lastBuf   = !curLink[LNK_CONT];
  assign remZero   = (curRem == '0);
  assign idxLast   = (idx == IDX_W'(DESC_WORDS - 1));
  assign alignBad  = (|curAddr[1:0]) || (curLink[LNK_CONT] && (|curRem[BURST_LG-1:0]));

endmodule

// File: rtl/chain_dma_control.sv
module chain_dma_control
  import chain_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWr,
  input  logic      ctrlEn,
  input  logic      ctrlList,
  input  logic      memRdValid,
  input  logic      beatAck,
  input  logic      alignBad,
  input  logic      lastBuf,
  input  logic      remZero,
  input  logic      idxLast,
  output dpStrobe_s strobe,
  output logic      memRdReq,
  output logic      bufValid,
  output logic      busy,
  output logic      done,
  output logic      errFlag
);

  dmaState_e state, stateNxt;
  logic      doneNxt;
  logic      stop;

  assign stop = ctrlWr && !ctrlEn;

  always_comb begin
    stateNxt = state;
    doneNxt  = 1'b0;
    strobe   = '0;
    strobe.listMode = ctrlList;
    case (state)
      ST_IDLE: begin
        if (ctrlWr && ctrlEn) begin
          strobe.start = 1'b1;
          stateNxt     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (alignBad) begin
          stateNxt = ST_ERR;
        end else if (remZero) begin
          if (lastBuf) begin
            stateNxt = ST_IDLE;
            doneNxt  = 1'b1;
          end else begin
            stateNxt = ST_FETCH;
          end
        end else begin
          stateNxt = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (remZero) begin
          if (lastBuf) begin
            stateNxt = ST_IDLE;
            doneNxt  = 1'b1;
          end else begin
            stateNxt = ST_FETCH;
          end
        end else begin
          strobe.beat = beatAck;
        end
      end
      ST_FETCH: begin
        if (memRdValid) begin
          strobe.capture = 1'b1;
          if (idxLast) stateNxt = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        strobe.commit = 1'b1;
        stateNxt      = ST_CHECK;
      end
      ST_ERR: ;
      default: stateNxt = ST_IDLE;
    endcase
    if (stop) begin
      stateNxt = ST_IDLE;
      doneNxt  = 1'b0;
      strobe   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
    end
  end

  assign memRdReq = (state == ST_FETCH);
  assign bufValid = (state == ST_STREAM) && !remZero;
  assign errFlag  = (state == ST_ERR);
  assign busy     = (state != ST_IDLE) && (state != ST_ERR);

endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int OFF_W       = 16,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic              memRdReq,
  output logic [WORD_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [WORD_W-1:0] memRdData,
  output logic              bufValid,
  output logic [WORD_W-1:0] bufAddr,
  output logic [WORD_W-1:0] bufRemain,
  input  logic              beatAck,
  output logic              busy,
  output logic              done,
  output logic              errFlag
);

  dpStrobe_s strobe;
  logic ctrlWr, ctrlEn, ctrlList, alignBad, lastBuf, remZero, idxLast;

  chain_dma_datapath #(
    .WORD_W(WORD_W), .OFF_W(OFF_W), .BURST_BYTES(BURST_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .memRdData(memRdData),
    .ctrlWr(ctrlWr), .ctrlEn(ctrlEn), .ctrlList(ctrlList),
    .memRdAddr(memRdAddr), .bufAddr(bufAddr), .bufRemain(bufRemain),
    .alignBad(alignBad), .lastBuf(lastBuf), .remZero(remZero),
    .idxLast(idxLast)
  );

  chain_dma_control u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlEn(ctrlEn),
    .ctrlList(ctrlList), .memRdValid(memRdValid), .beatAck(beatAck),
    .alignBad(alignBad), .lastBuf(lastBuf), .remZero(remZero),
    .idxLast(idxLast), .strobe(strobe), .memRdReq(memRdReq),
    .bufValid(bufValid), .busy(busy), .done(done), .errFlag(errFlag)
  );

endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker
  import chain_dma_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [WORD_W-1:0] regWrData,
  input logic              memRdReq,
  input logic [WORD_W-1:0] memRdAddr,
  input logic              memRdValid,
  input logic              bufValid,
  input logic [WORD_W-1:0] bufAddr,
  input logic              beatAck,
  input logic              busy,
  input logic              done,
  input logic              errFlag
);

  logic stopWr;
  assign stopWr = regWrEn && (regAddr == RA_CTRL) && !regWrData[0];

  // R4: a pending read holds its request and address
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid && !stopWr) |=> (memRdReq && $stable(memRdAddr)));

  // R5: no buffer is offered while a descriptor is being read
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(bufValid && memRdReq));

  // R3: an accepted beat moves the address by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && beatAck && !stopWr) |=> (bufAddr == $past(bufAddr) + WORD_W'(BEAT_BYTES)));

  // R9: an error halts all activity
  a_r9_err_halts: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!busy && !bufValid && !memRdReq));

  // R10: a stop write returns the engine to idle
  a_r10_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!busy && !bufValid && !memRdReq && !errFlag));

  // R11: done is a single-cycle pulse seen while idle
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind chain_dma chain_dma_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
  .memRdValid(memRdValid), .bufValid(bufValid), .bufAddr(bufAddr),
  .beatAck(beatAck), .busy(busy), .done(done), .errFlag(errFlag)
);

// File: tb/sim_chain_dma.sv
`timescale 1ns/1ps
module sim_chain_dma;

  localparam logic [31:0] F_CONT = 32'h8000_0000;
  localparam logic [31:0] F_SIZE = 32'h4000_0000;
  localparam logic [31:0] F_BASE = 32'h2000_0000;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] size;
    logic [7:0]  beats;
    logic        err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 32'd16, 8'd4,  1'b0},
    '{32'h0000_0204, 32'd5,  8'd2,  1'b0},
    '{32'h0000_0300, 32'd1,  8'd1,  1'b0},
    '{32'h0000_0401, 32'd8,  8'd0,  1'b1},
    '{32'h0000_0500, 32'd0,  8'd0,  1'b0},
    '{32'h0000_0602, 32'd4,  8'd0,  1'b1},
    '{32'h0000_0700, 32'd64, 8'd16, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        bufValid;
  logic [31:0] bufAddr;
  logic [31:0] bufRemain;
  logic        beatAck = 1'b0;
  logic        busy, done, errFlag;

  int checks = 0;
  int fails  = 0;
  int beatCnt = 0, rdCnt = 0, doneCnt = 0, overlap = 0, latCnt = 0;
  logic [31:0] beatLog [64];
  logic [31:0] remLog  [64];
  logic [31:0] rdLog   [16];
  logic [31:0] mem     [64];

  always #4 clk = ~clk;

  chain_dma u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .bufValid(bufValid),
    .bufAddr(bufAddr), .bufRemain(bufRemain), .beatAck(beatAck),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  // data path and memory models, all acting on the falling edge
  always @(negedge clk) begin
    beatAck <= bufValid;
    if (bufValid) begin
      if (beatCnt < 64) begin
        beatLog[beatCnt] <= bufAddr;
        remLog[beatCnt]  <= bufRemain;
      end
      beatCnt <= beatCnt + 1;
    end
    if (bufValid && memRdReq) overlap <= overlap + 1;
    if (done) doneCnt <= doneCnt + 1;
    if (memRdReq) begin
      if (latCnt == 1) begin
        memRdValid <= 1'b1;
        memRdData  <= mem[memRdAddr[7:2]];
        if (rdCnt < 16) rdLog[rdCnt] <= memRdAddr;
        rdCnt  <= rdCnt + 1;
        latCnt <= 0;
      end else begin
        memRdValid <= 1'b0;
        latCnt <= latCnt + 1;
      end
    end else begin
      memRdValid <= 1'b0;
      latCnt <= 0;
    end
  end

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic clearLogs();
    @(negedge clk);
    beatCnt = 0; rdCnt = 0; doneCnt = 0; overlap = 0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, {tag, " watchdog"}, 32'(busy), 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // chain A: descriptor 1 at 0x40, descriptor 2 at 0x4C
    mem[16] = F_CONT | 32'h0C;      // continue, keep base and size
    mem[17] = 32'hDEAD_0000;
    mem[18] = 32'd99;
    mem[19] = F_BASE | F_SIZE;      // last, new base and size
    mem[20] = 32'h0000_2000;
    mem[21] = 32'd6;
    // chain C: misaligned descriptor at 0x60
    mem[24] = F_BASE | F_SIZE;
    mem[25] = 32'h0000_3002;
    mem[26] = 32'd8;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !bufValid && !memRdReq && !done && !errFlag, "R1 reset outputs",
          {27'd0, busy, bufValid, memRdReq, done, errFlag}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R9 R11: table of single-buffer transfers
    for (int v = 0; v < NV; v++) begin
      clearLogs();
      wr(3'd1, 32'h40);
      wr(3'd2, F_CONT | 32'h0);
      wr(3'd3, VECS[v].base);
      wr(3'd4, VECS[v].size);
      wr(3'd0, 32'h1);
      waitIdle("R2 single");
      check(beatCnt == int'(VECS[v].beats), "R3 beat count", 32'(beatCnt), 32'(VECS[v].beats));
      check(rdCnt == 0, "R2 no descriptor read", 32'(rdCnt), 32'd0);
      check(errFlag == VECS[v].err, "R9 alignment error", 32'(errFlag), 32'(VECS[v].err));
      check(doneCnt == (VECS[v].err ? 0 : 1), "R11 done count", 32'(doneCnt),
            VECS[v].err ? 32'd0 : 32'd1);
      for (int b = 0; b < int'(VECS[v].beats); b++) begin
        check(beatLog[b] == VECS[v].base + 32'(4 * b), "R3 beat address",
              beatLog[b], VECS[v].base + 32'(4 * b));
        check(remLog[b] == VECS[v].size - 32'(4 * b), "R3 remaining bytes",
              remLog[b], VECS[v].size - 32'(4 * b));
      end
      if (VECS[v].err) begin
        wr(3'd0, 32'h0);
        check(!errFlag && !busy, "R10 stop clears error", 32'(errFlag), 32'd0);
      end
    end

    // chain A: R4 R5 R6 R7 R8
    clearLogs();
    wr(3'd1, 32'h40);
    wr(3'd2, F_CONT | 32'h0);
    wr(3'd3, 32'h1000);
    wr(3'd4, 32'd32);
    wr(3'd0, 32'h3);
    waitIdle("R6 chain");
    check(beatCnt == 18, "R6 chain beat count", 32'(beatCnt), 32'd18);
    check(rdCnt == 6, "R6 reads stop at last", 32'(rdCnt), 32'd6);
    for (int r = 0; r < 6; r++)
      check(rdLog[r] == 32'h40 + 32'(4 * r), "R4 fetch address order", rdLog[r], 32'h40 + 32'(4 * r));
    check(overlap == 0, "R5 no buffer during fetch", 32'(overlap), 32'd0);
    check(beatLog[8] == 32'h1020, "R8 base continues", beatLog[8], 32'h1020);
    check(remLog[8] == 32'd32, "R7 size reused", remLog[8], 32'd32);
    check(beatLog[16] == 32'h2000, "R8 base reloaded", beatLog[16], 32'h2000);
    check(remLog[16] == 32'd6 && remLog[17] == 32'd2, "R7 size reloaded", remLog[17], 32'd2);
    check(doneCnt == 1 && !errFlag, "R11 chain done", 32'(doneCnt), 32'd1);

    // R9: non-last first buffer with a size that is not a burst multiple
    clearLogs();
    wr(3'd2, F_CONT | 32'h0);
    wr(3'd3, 32'h1000);
    wr(3'd4, 32'd20);
    wr(3'd0, 32'h3);
    waitIdle("R9 size");
    check(errFlag && beatCnt == 0 && rdCnt == 0, "R9 burst size error", 32'(beatCnt), 32'd0);
    wr(3'd0, 32'h0);

    // R9: misaligned base in a fetched descriptor
    clearLogs();
    wr(3'd2, F_CONT | 32'h20);
    wr(3'd3, 32'h1000);
    wr(3'd4, 32'd16);
    wr(3'd0, 32'h3);
    waitIdle("R9 fetched");
    check(errFlag && beatCnt == 4 && doneCnt == 0, "R9 fetched base error", 32'(beatCnt), 32'd4);
    repeat (4) @(negedge clk);
    check(beatCnt == 4 && !bufValid, "R9 halted after error", 32'(beatCnt), 32'd4);
    wr(3'd0, 32'h0);
    check(!errFlag, "R10 error cleared", 32'(errFlag), 32'd0);

    // R10: stop in the middle of a buffer
    clearLogs();
    wr(3'd3, 32'h800);
    wr(3'd4, 32'd64);
    wr(3'd0, 32'h1);
    repeat (4) @(negedge clk);
    wr(3'd0, 32'h1);        // ignored while busy
    check(busy, "R10 enable while busy ignored", 32'(busy), 32'd1);
    wr(3'd0, 32'h0);
    check(!busy && !bufValid, "R10 stop halts", 32'(busy), 32'd0);
    repeat (4) @(negedge clk);
    check(beatCnt < 16 && doneCnt == 0, "R10 no done after stop", 32'(doneCnt), 32'd0);

    summary();
  end

endmodule